// File: doc/BRIEF.md
# Nibble Bus CRC Accumulator

This block keeps a 16-bit running checksum over the 4-bit data nibbles that move across a nibble-wide memory bus. Each cycle the bus may present one nibble, tagged with where it came from (ordinary memory or the 64-nibble I/O register window) and how it was accessed (read, write or side-effect-free debug read). A qualifier decides whether that nibble is absorbed. If it is, the register folds the whole nibble in within one clock using a multiply-by-constant form.

Ordinary memory reads always contribute, including the filler nibbles returned for unmapped space. I/O window reads contribute only their final nibble, and only when the access runs up to the top offset of the window. Writes and debug reads never touch the value. Software reads the checksum from a port and can seed it with a full 16-bit load, which wins over a nibble arriving in the same cycle.

Top module: `nib_crc_acc`

## Requirements
- R1: While rst_ni is low the checksum output reads 0x0000, and it stays 0x0000 after reset is released until a nibble is absorbed or a load occurs.
- R2: A memory read nibble (nib_vld_i=1, src_io_i=0, is_write_i=0, is_peek_i=0, load_i=0) updates the checksum on the next clock to new = (old >> 4) XOR (((old XOR nibble) AND 0xF) * 0x1081), truncated to 16 bits.
- R3: Memory read nibbles with the unmapped filler values 0xD and 0xE are absorbed by the same rule as any other nibble value.
- R4: An I/O window read (src_io_i=1) with win_last_i=0 leaves the checksum unchanged.
- R5: An I/O window read with win_last_i=1 (the final nibble of an access that reaches window offset 0x3F) is absorbed by the R2 rule.
- R6: A write (is_write_i=1) leaves the checksum unchanged, for either source.
- R7: A debug read (is_peek_i=1) leaves the checksum unchanged, for either source.
- R8: load_i=1 sets the checksum to load_val_i on the next clock.
- R9: When load_i=1 and an absorbable nibble arrive in the same cycle, the checksum takes load_val_i and the nibble is dropped.
- R10: With nib_vld_i=0 and load_i=0 the checksum holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nib_vld_i | input | 1 | A bus nibble is present this cycle |
| nib_i | input | 4 | Bus data nibble |
| src_io_i | input | 1 | 1: nibble belongs to the I/O register window; 0: ordinary memory |
| is_write_i | input | 1 | 1: access is a write |
| is_peek_i | input | 1 | 1: access is a side-effect-free debug read |
| win_last_i | input | 1 | 1: final nibble of an I/O access ending at window offset 0x3F |
| load_i | input | 1 | Overwrite the checksum with load_val_i |
| load_val_i | input | 16 | Seed value |
| crc_o | output | 16 | Current checksum |

## Verification
Since the checksum is the only state, any corruption appears on crc_o one clock after the offending cycle: a wrongly qualified nibble shows as a changed value where a stable one was expected, and a faulty fold shows as a mismatch against an arithmetic model that uses a true integer multiply. Because each update shifts the old value by only four bits, a bad bit keeps affecting the output for at least four further absorbed nibbles, so short chains of mixed accesses expose it. Seeds with all-zero, all-one and mixed patterns make sure the fold is exercised across every bit lane.

// File: rtl/nib_crc_pkg.sv
package nib_crc_pkg;
  localparam int unsigned CRC_W = 16;
  localparam int unsigned NIB_W = 4;
  localparam logic [CRC_W-1:0] FOLD_MULT = 16'h1081;

  typedef logic [CRC_W-1:0] crc_t;
  typedef logic [NIB_W-1:0] nib_t;
endpackage

// File: rtl/nib_crc_qual.sv
module nib_crc_qual (
  input  logic nib_vld_i,
  input  logic src_io_i,
  input  logic is_write_i,
  input  logic is_peek_i,
  input  logic win_last_i,
  output logic feed_o
);
  logic plain_rd;

  // only real reads count; I/O window contributes on its top-offset nibble
  assign plain_rd = nib_vld_i && !is_write_i && !is_peek_i;
  assign feed_o   = plain_rd && (!src_io_i || win_last_i);
endmodule

// File: rtl/nib_crc_fold.sv
module nib_crc_fold #(
  parameter int unsigned CRC_W = 16,
  parameter int unsigned NIB_W = 4,
  parameter logic [CRC_W-1:0] MULT = 16'h1081
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [NIB_W-1:0] mix;
  logic [CRC_W-1:0] part [CRC_W];
  logic [CRC_W-1:0] prod;

  assign mix = crc_i[NIB_W-1:0] ^ nib_i;

  // constant multiply as XOR of shifted copies, one per set bit of MULT
  for (genvar k = 0; k < CRC_W; k++) begin : g_tap
    if (MULT[k]) begin : g_on
      assign part[k] = CRC_W'(mix) << k;
    end else begin : g_off
      assign part[k] = '0;
    end
  end

  always_comb begin
    prod = '0;
    for (int k = 0; k < CRC_W; k++) prod = prod ^ part[k];
  end

  assign crc_o = (crc_i >> NIB_W) ^ prod;
endmodule

// File: rtl/nib_crc_acc.sv
module nib_crc_acc
  import nib_crc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        nib_vld_i,
  input  logic [3:0]  nib_i,
  input  logic        src_io_i,
  input  logic        is_write_i,
  input  logic        is_peek_i,
  input  logic        win_last_i,
  input  logic        load_i,
  input  logic [15:0] load_val_i,
  output logic [15:0] crc_o
);
  crc_t crc_q, crc_nxt;
  logic feed;

  nib_crc_qual u_qual (
    .nib_vld_i (nib_vld_i),
    .src_io_i  (src_io_i),
    .is_write_i(is_write_i),
    .is_peek_i (is_peek_i),
    .win_last_i(win_last_i),
    .feed_o    (feed)
  );

  nib_crc_fold #(
    .CRC_W(CRC_W),
    .NIB_W(NIB_W),
    .MULT (FOLD_MULT)
  ) u_fold (
    .crc_i(crc_q),
    .nib_i(nib_i),
    .crc_o(crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '0;
    else if (load_i) crc_q <= load_val_i;  // load wins over a nibble
    else if (feed)   crc_q <= crc_nxt;
  end

  assign crc_o = crc_q;

  a_r8_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> crc_o == $past(load_val_i));
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nib_vld_i && !load_i) |=> $stable(crc_o));
  a_r6_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_vld_i && is_write_i && !load_i) |=> $stable(crc_o));
  a_r7_peek_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_vld_i && is_peek_i && !load_i) |=> $stable(crc_o));
  a_r4_io_mid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_vld_i && src_io_i && !win_last_i && !load_i) |=> $stable(crc_o));
  a_r5_io_top_feeds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_vld_i && src_io_i && win_last_i && !is_write_i && !is_peek_i) |-> feed);
endmodule

// File: tb/tb_nib_crc_acc.sv
module tb_nib_crc_acc;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        nib_vld_i = 1'b0;
  logic [3:0]  nib_i = '0;
  logic        src_io_i = 1'b0;
  logic        is_write_i = 1'b0;
  logic        is_peek_i = 1'b0;
  logic        win_last_i = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] load_val_i = '0;
  logic [15:0] crc_o;

  int checks = 0;
  int fails = 0;
  logic [15:0] model = '0;

  always #10 clk = ~clk;  // 50 MHz

  nib_crc_acc dut (
    .clk_i(clk), .rst_ni(rst_ni), .nib_vld_i(nib_vld_i), .nib_i(nib_i),
    .src_io_i(src_io_i), .is_write_i(is_write_i), .is_peek_i(is_peek_i),
    .win_last_i(win_last_i), .load_i(load_i), .load_val_i(load_val_i),
    .crc_o(crc_o)
  );

  function automatic logic [15:0] step(logic [15:0] c, logic [3:0] n);
    int unsigned p;
    p = ((int'(c) ^ int'(n)) & 15) * 32'h1081;
    return (c >> 4) ^ p[15:0];
  endfunction

  task automatic check(string req, logic [15:0] exp);
    checks++;
    if (crc_o !== exp) begin
      fails++;
      $display("FAIL %s crc actual=%h expected=%h", req, crc_o, exp);
    end
  endtask

  // drive one cycle at negedge, sample at following negedge
  task automatic cyc(logic v, logic [3:0] n, logic io, logic wr, logic pk,
                     logic last, logic ld, logic [15:0] lv);
    nib_vld_i = v; nib_i = n; src_io_i = io; is_write_i = wr;
    is_peek_i = pk; win_last_i = last; load_i = ld; load_val_i = lv;
    @(negedge clk);
    nib_vld_i = 0; load_i = 0; is_write_i = 0; is_peek_i = 0;
    src_io_i = 0; win_last_i = 0;
  endtask

  task automatic seed(logic [15:0] v);
    cyc(0, 0, 0, 0, 0, 0, 1, v);
    model = v;
    check("R8", model);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", 16'h0000);
  endtask

  task automatic t_mem_reads();
    logic [3:0] pat [6] = '{4'h1, 4'h0, 4'hF, 4'h7, 4'hA, 4'h5};
    for (int i = 0; i < 6; i++) begin
      cyc(1, pat[i], 0, 0, 0, 0, 0, 0);
      model = step(model, pat[i]);
      check("R2", model);
    end
    seed(16'hFFFF);
    for (int i = 0; i < 8; i++) begin
      cyc(1, 4'(i * 3 + 1), 0, 0, 0, 0, 0, 0);
      model = step(model, 4'(i * 3 + 1));
      check("R2", model);
    end
  endtask

  task automatic t_filler();
    seed(16'h5A3C);
    for (int i = 0; i < 6; i++) begin
      logic [3:0] f;
      f = (i % 2 == 1) ? 4'hE : 4'hD;
      cyc(1, f, 0, 0, 0, 0, 0, 0);
      model = step(model, f);
      check("R3", model);
    end
  endtask

  task automatic t_io_window();
    seed(16'h1234);
    for (int i = 0; i < 3; i++) begin
      cyc(1, 4'h9, 1, 0, 0, 0, 0, 0);
      check("R4", model);
    end
    cyc(1, 4'hB, 1, 0, 0, 1, 0, 0);
    model = step(model, 4'hB);
    check("R5", model);
    cyc(1, 4'h3, 1, 0, 0, 1, 0, 0);
    model = step(model, 4'h3);
    check("R5", model);
  endtask

  task automatic t_write_peek();
    seed(16'hC0DE);
    cyc(1, 4'h6, 0, 1, 0, 0, 0, 0);  check("R6", model);
    cyc(1, 4'h6, 1, 1, 0, 1, 0, 0);  check("R6", model);
    cyc(1, 4'h2, 0, 0, 1, 0, 0, 0);  check("R7", model);
    cyc(1, 4'h2, 1, 0, 1, 1, 0, 0);  check("R7", model);
    cyc(1, 4'h2, 0, 0, 0, 0, 0, 0);
    model = step(model, 4'h2);
    check("R2", model);
  endtask

  task automatic t_load_prio();
    seed(16'h0000);
    cyc(1, 4'hF, 0, 0, 0, 0, 1, 16'hBEEF);
    model = 16'hBEEF;
    check("R9", model);
    cyc(1, 4'h4, 1, 0, 0, 1, 1, 16'h8001);
    model = 16'h8001;
    check("R9", model);
  endtask

  task automatic t_idle();
    seed(16'h7E57);
    for (int i = 0; i < 4; i++) begin
      cyc(0, 4'(i), 0, 0, 0, 0, 0, 16'hFFFF);
      check("R10", model);
    end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_mem_reads();
    t_filler();
    t_io_window();
    t_write_peek();
    t_load_prio();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule